// File: doc/BRIEF.md
# Full-duplex serial port with ninth-bit addressing

The block is an asynchronous serial transmitter and receiver that shares one 8-bit control and status register. It runs from a baud tick supplied from outside at sixteen ticks per bit. A frame has one start bit, data sent least significant bit first, an optional ninth bit, and one stop bit. Software picks one of two frame formats: nine data bits or eight. In the nine-bit format, software sets the ninth bit to send, and the receiver stores the ninth bit it sees. In the eight-bit format, the receiver stores the stop bit it sees in that same field.

A multiprocessor filter lets a node on a shared line ignore traffic that is not addressed to it. When the filter is on, a received frame raises the receive flag and updates the receive buffer only if the frame qualifies:
- in the nine-bit format, its ninth bit must be 1;
- in the eight-bit format, its stop bit must be high.

A frame that arrives while the receive flag is still set is dropped, so an unread byte is never overwritten. The interrupt output is high while either completion flag is set.

The register port uses a one-bit select: 0 picks the control register and 1 picks the data buffer. A write to the data buffer starts a transmission. A read of the data buffer returns the last byte accepted by the receiver.

Top module: `sercom9`

## Requirements
- R1: After reset the control register reads 0x00, the receive buffer reads 0x00, the serial output is high and the interrupt output is low.
- R2: With control bit 7 set (eight-bit format), a data write while idle sends a low start bit, the eight data bits least significant first, then a high stop bit. Each bit lasts 16 baud ticks.
- R3: Control bit 1 is set when the stop bit of a sent frame ends. The interrupt output always equals bit 1 OR bit 0.
- R4: With control bit 7 clear (nine-bit format), control bit 3 is sent as a ninth bit between the eighth data bit and the stop bit.
- R5: A data write while a frame is being sent is ignored. The frame in flight is unchanged and no further frame follows it.
- R6: A control write replaces bits 7, 5, 4, 3, 2, 1 and 0 with the written value, which is how software clears the flags. Bit 6 always reads 0.
- R7: In the eight-bit format with bit 5 clear, a received frame is accepted even with a low stop bit. Bit 2 takes the sampled stop bit, bit 0 is set and the data buffer takes the byte.
- R8: In the nine-bit format with bit 5 clear, a received frame is accepted and bit 2 takes its ninth bit.
- R9: While bit 0 is set, a completed frame is discarded and the data buffer and bit 2 keep their values.
- R10: While bit 4 is clear, no frame is received.
- R11: In the nine-bit format with bit 5 set, only frames whose ninth bit is 1 are accepted.
- R12: In the eight-bit format with bit 5 set, only frames whose stop bit is high are accepted.
- R13: Each received bit is decided by a majority of three samples, taken at oversample ticks 7, 8 and 9 after the bit's start. A start bit that does not vote low is abandoned, so a low pulse of two ticks is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | Oversample strobe, 16 per bit |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control, 1 transmit data |
| wr_data | input | 8 | Write value |
| rd_sel | input | 1 | Read source: 0 control, 1 receive data |
| rd_data | output | 8 | Read value |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input |
| irq | output | 1 | Interrupt, high while a completion flag is set |

## Verification
The bench builds the block with its defaults: 16 oversample ticks per bit and 8-bit data.

It drives the baud tick once every four clocks, so a full eleven-bit frame takes about 700 clocks. That keeps every format, both filter cases, the full-buffer drop and the disabled receiver within a short run.

The bench decodes the serial output at mid-bit, on its own tick count. It also drives frames onto the serial input with chosen stop and ninth bits, including a deliberately low stop bit and a two-tick start glitch. On every clock it compares the interrupt output against the flags read back from the port.

// File: rtl/sercom9_pkg.sv
package sercom9_pkg;
  typedef struct packed {
    logic fmt8;
    logic mp_en;
    logic rx_en;
    logic tx_b9;
    logic rx_b9;
    logic tx_flag;
    logic rx_flag;
  } ctrl_t;
endpackage

// File: rtl/sercom9_tx.sv
module sercom9_tx #(
  parameter int OSR = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          load,
  input  logic          nine,
  input  logic          b9,
  input  logic [DW-1:0] din,
  output logic          txd,
  output logic          busy,
  output logic          done
);
  localparam int FW = DW + 3;
  localparam int CW = $clog2(OSR);
  localparam int NW = $clog2(FW + 1);

  logic          busy_q, busy_d;
  logic [FW-1:0] sh_q, sh_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [NW-1:0] left_q, left_d;
  logic          bit_end;

  always_comb begin
    busy_d  = busy_q;
    sh_d    = sh_q;
    cnt_d   = cnt_q;
    left_d  = left_q;
    bit_end = busy_q && tick && (cnt_q == CW'(OSR - 1));
    done    = bit_end && (left_q == NW'(1));
    if (!busy_q && load) begin
      busy_d = 1'b1;
      sh_d   = {1'b1, (nine ? b9 : 1'b1), din, 1'b0};
      cnt_d  = '0;
      left_d = nine ? NW'(DW + 3) : NW'(DW + 2);
    end else if (busy_q && tick) begin
      cnt_d = cnt_q + 1'b1;
      if (bit_end) begin
        cnt_d  = '0;
        sh_d   = {1'b1, sh_q[FW-1:1]};
        left_d = left_q - 1'b1;
        if (left_q == NW'(1)) busy_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sh_q   <= '1;
      cnt_q  <= '0;
      left_q <= '0;
    end else begin
      busy_q <= busy_d;
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      left_q <= left_d;
    end
  end

  assign txd  = busy_q ? sh_q[0] : 1'b1;
  assign busy = busy_q;

  // R2: the frame always ends while the stop level is on the line
  assert_stop_at_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> txd);
  // R5: the shifter only moves at bit boundaries once a frame is under way
  assert_busy_ignores_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !bit_end) |=> $stable(sh_q));
endmodule

// File: rtl/sercom9_rx.sv
module sercom9_rx #(
  parameter int OSR = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          rxd,
  input  logic          en,
  input  logic          nine,
  output logic          fin,
  output logic [DW-1:0] data,
  output logic          ninth,
  output logic          stop,
  output logic          idle
);
  localparam int CW  = $clog2(OSR);
  localparam int IW  = $clog2(DW + 3);
  localparam int MID = OSR / 2;

  logic [1:0]    sync_q;
  logic          line, maj;
  logic          run_q, run_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [IW-1:0] idx_q, idx_d, stop_idx;
  logic          sa_q, sa_d, sb_q, sb_d;
  logic [DW-1:0] sh_q, sh_d;
  logic          nin_q, nin_d, stp_q, stp_d, fin_q, fin_d;

  assign line     = sync_q[1];
  assign maj      = (sa_q & sb_q) | (sa_q & line) | (sb_q & line);
  assign stop_idx = nine ? IW'(DW + 2) : IW'(DW + 1);

  always_comb begin
    run_d = run_q;
    cnt_d = cnt_q;
    idx_d = idx_q;
    sa_d  = sa_q;
    sb_d  = sb_q;
    sh_d  = sh_q;
    nin_d = nin_q;
    stp_d = stp_q;
    fin_d = 1'b0;
    if (!run_q) begin
      if (en && !line) begin
        run_d = 1'b1;
        cnt_d = '0;
        idx_d = '0;
      end
    end else if (tick) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == CW'(MID - 1)) sa_d = line;
      if (cnt_q == CW'(MID))     sb_d = line;
      if (cnt_q == CW'(MID + 1)) begin
        if (idx_q == '0) begin
          if (maj) run_d = 1'b0;
        end else if (idx_q == stop_idx) begin
          run_d = 1'b0;
          fin_d = 1'b1;
          stp_d = maj;
        end else if (idx_q == IW'(DW + 1)) begin
          nin_d = maj;
        end else begin
          sh_d = {maj, sh_q[DW-1:1]};
        end
      end
      if (cnt_q == CW'(OSR - 1)) begin
        cnt_d = '0;
        idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      run_q  <= 1'b0;
      cnt_q  <= '0;
      idx_q  <= '0;
      sa_q   <= 1'b1;
      sb_q   <= 1'b1;
      sh_q   <= '0;
      nin_q  <= 1'b0;
      stp_q  <= 1'b1;
      fin_q  <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], rxd};
      run_q  <= run_d;
      cnt_q  <= cnt_d;
      idx_q  <= idx_d;
      sa_q   <= sa_d;
      sb_q   <= sb_d;
      sh_q   <= sh_d;
      nin_q  <= nin_d;
      stp_q  <= stp_d;
      fin_q  <= fin_d;
    end
  end

  assign fin   = fin_q;
  assign data  = sh_q;
  assign ninth = nin_q;
  assign stop  = stp_q;
  assign idle  = !run_q;

  // R10: with reception off, an idle receiver never starts a frame
  assert_off_stays_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !en) |=> !run_q);
  // R13: a completion is a single pulse and leaves the receiver idle
  assert_fin_leaves_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
    fin_q |-> (!run_q && $past(run_q)));
endmodule

// File: rtl/sercom9.sv
module sercom9
  import sercom9_pkg::*;
#(
  parameter int OSR = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          baud_tick,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_sel,
  output logic [DW-1:0] rd_data,
  output logic          txd,
  input  logic          rxd,
  output logic          irq
);
  ctrl_t         c_q, c_d;
  logic [DW-1:0] buf_q, buf_d;
  logic          tx_busy, tx_done;
  logic          rx_fin, rx_ninth, rx_stop, rx_idle;
  logic [DW-1:0] rx_data;
  logic          ctrl_wr, qualify, accept;
  logic [7:0]    ctrl_byte;

  sercom9_tx #(.OSR(OSR), .DW(DW)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick),
    .load(wr_en && wr_sel), .nine(!c_q.fmt8), .b9(c_q.tx_b9),
    .din(wr_data), .txd(txd), .busy(tx_busy), .done(tx_done)
  );

  sercom9_rx #(.OSR(OSR), .DW(DW)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .rxd(rxd),
    .en(c_q.rx_en), .nine(!c_q.fmt8), .fin(rx_fin), .data(rx_data),
    .ninth(rx_ninth), .stop(rx_stop), .idle(rx_idle)
  );

  assign ctrl_wr   = wr_en && !wr_sel;
  assign qualify   = c_q.fmt8 ? (!c_q.mp_en || rx_stop) : (!c_q.mp_en || rx_ninth);
  assign accept    = rx_fin && !c_q.rx_flag && qualify;
  assign ctrl_byte = {c_q.fmt8, 1'b0, c_q.mp_en, c_q.rx_en,
                      c_q.tx_b9, c_q.rx_b9, c_q.tx_flag, c_q.rx_flag};

  always_comb begin
    c_d   = c_q;
    buf_d = buf_q;
    if (ctrl_wr) begin
      c_d.fmt8    = wr_data[7];
      c_d.mp_en   = wr_data[5];
      c_d.rx_en   = wr_data[4];
      c_d.tx_b9   = wr_data[3];
      c_d.rx_b9   = wr_data[2];
      c_d.tx_flag = wr_data[1];
      c_d.rx_flag = wr_data[0];
    end
    if (tx_done) c_d.tx_flag = 1'b1;
    if (accept) begin
      c_d.rx_flag = 1'b1;
      c_d.rx_b9   = c_q.fmt8 ? rx_stop : rx_ninth;
      buf_d       = rx_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_q   <= '0;
      buf_q <= '0;
    end else begin
      c_q   <= c_d;
      buf_q <= buf_d;
    end
  end

  assign rd_data = rd_sel ? buf_q : DW'(ctrl_byte);
  assign irq     = c_q.tx_flag | c_q.rx_flag;

  // R3: the transmit flag persists until software writes the control register
  assert_txflag_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (c_q.tx_flag && !ctrl_wr) |=> c_q.tx_flag);
  // R9: an unread byte is never replaced
  assert_full_keeps_buffer_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (c_q.rx_flag && !ctrl_wr) |=> ($stable(buf_q) && $stable(c_q.rx_b9)));
  // R11: with the filter on in nine-bit format, a new byte implies ninth bit 1
  assert_filter_nine_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!c_q.fmt8 && c_q.mp_en && !ctrl_wr && !c_q.rx_flag) |=> (!c_q.rx_flag || c_q.rx_b9));
endmodule

// File: tb/tb_sercom9.sv
module tb_sercom9;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_sel = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       rd_sel = 1'b0;
  logic       rxd = 1'b1;
  logic [7:0] rd_data;
  logic       txd, irq, baud_tick;
  logic [1:0] tk;
  int n_chk = 0, n_fail = 0, irq_chk = 0, irq_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) tk <= 2'd0;
    else        tk <= tk + 2'd1;
  assign baud_tick = (tk == 2'd3);

  sercom9 #(.OSR(16), .DW(8)) dut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .txd(txd), .rxd(rxd), .irq(irq)
  );

  // R3 reference: interrupt equals OR of the two flags, compared every clock
  always @(negedge clk) begin
    if (rst_n && !rd_sel) begin
      irq_chk++;
      if (irq !== (rd_data[1] | rd_data[0])) begin
        irq_fail++;
        $display("FAIL R3 irq act=%0b exp=%0b", irq, rd_data[1] | rd_data[0]);
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    repeat (n) begin
      @(negedge clk);
      while (!baud_tick) @(negedge clk);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [7:0] v);
    @(negedge clk);
    rd_sel = sel;
    #1 v = rd_data;
    #0.5 rd_sel = 1'b0;
  endtask

  task automatic send_frame(input logic [11:0] bits, input int n);
    for (int i = 0; i < n; i++) begin
      rxd = bits[i];
      wait_ticks(16);
    end
    rxd = 1'b1;
    wait_ticks(20);
  endtask

  task automatic get_tx(input int n, output logic [11:0] got);
    got = '0;
    while (txd !== 1'b0) @(negedge clk);
    wait_ticks(8);
    for (int i = 0; i < n; i++) begin
      got[i] = txd;
      if (i < n - 1) wait_ticks(16);
    end
  endtask

  task automatic expect_rx(input string req, input logic [7:0] c, input logic [7:0] d);
    logic [7:0] v;
    rd(1'b0, v); chk({req, " ctrl"}, v, c);
    rd(1'b1, v); chk({req, " data"}, v, d);
  endtask

  function automatic logic [11:0] f8(input logic [7:0] d, input logic s);
    return {3'b000, s, d, 1'b0};
  endfunction
  function automatic logic [11:0] f9(input logic [7:0] d, input logic b);
    return {2'b00, 1'b1, b, d, 1'b0};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog act=running exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk + irq_chk, n_fail + irq_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0]  v;
    logic [11:0] got;
    int          low_seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    rd(1'b0, v); chk("R1 ctrl", v, 8'h00);
    rd(1'b1, v); chk("R1 data", v, 8'h00);
    chk("R1 txd", txd, 1'b1);
    chk("R1 irq", irq, 1'b0);

    // R2, R3: eight-bit transmit
    wr(1'b0, 8'h80);
    wr(1'b1, 8'hA5);
    get_tx(10, got);
    chk("R2 frame", got, {2'b00, 1'b1, 8'hA5, 1'b0});
    wait_ticks(10);
    rd(1'b0, v); chk("R3 txflag", v, 8'h82);
    chk("R3 irq", irq, 1'b1);

    // R6: control write clears flags
    wr(1'b0, 8'h80);
    rd(1'b0, v); chk("R6 clear", v, 8'h80);
    chk("R6 irq", irq, 1'b0);

    // R4: nine-bit transmit with ninth 1 then 0
    wr(1'b0, 8'h08);
    wr(1'b1, 8'h3C);
    get_tx(11, got);
    chk("R4 ninth1", got, {1'b0, 1'b1, 1'b1, 8'h3C, 1'b0});
    wait_ticks(10);
    wr(1'b0, 8'h00);
    wr(1'b1, 8'hC3);
    get_tx(11, got);
    chk("R4 ninth0", got, {1'b0, 1'b1, 1'b0, 8'hC3, 1'b0});
    wait_ticks(10);

    // R5: write during a frame is ignored
    wr(1'b0, 8'h80);
    fork
      get_tx(10, got);
      begin wr(1'b1, 8'h11); wait_ticks(30); wr(1'b1, 8'hEE); end
    join
    chk("R5 frame", got, {2'b00, 1'b1, 8'h11, 1'b0});
    low_seen = 0;
    repeat (48 * 4) begin @(negedge clk); if (!txd) low_seen++; end
    chk("R5 quiet", low_seen, 0);

    // R7: eight-bit receive, stop captured, low stop accepted
    wr(1'b0, 8'h90);
    send_frame(f8(8'h3C, 1'b1), 10);
    expect_rx("R7 good", 8'h95, 8'h3C);
    wr(1'b0, 8'h90);
    send_frame(f8(8'h71, 1'b0), 10);
    expect_rx("R7 lowstop", 8'h91, 8'h71);

    // R8: nine-bit receive
    wr(1'b0, 8'h10);
    send_frame(f9(8'h5A, 1'b1), 11);
    expect_rx("R8 ninth1", 8'h15, 8'h5A);
    wr(1'b0, 8'h10);
    send_frame(f9(8'hA6, 1'b0), 11);
    expect_rx("R8 ninth0", 8'h11, 8'hA6);

    // R9: full buffer drops the next frame
    send_frame(f9(8'h0F, 1'b1), 11);
    expect_rx("R9 drop", 8'h11, 8'hA6);

    // R10: reception disabled
    wr(1'b0, 8'h00);
    send_frame(f9(8'h77, 1'b1), 11);
    expect_rx("R10 off", 8'h00, 8'hA6);

    // R11: nine-bit filter
    wr(1'b0, 8'h30);
    send_frame(f9(8'h42, 1'b0), 11);
    expect_rx("R11 reject", 8'h30, 8'hA6);
    send_frame(f9(8'h43, 1'b1), 11);
    expect_rx("R11 accept", 8'h35, 8'h43);

    // R12: eight-bit filter on stop bit
    wr(1'b0, 8'hB0);
    send_frame(f8(8'h99, 1'b0), 10);
    expect_rx("R12 reject", 8'hB0, 8'h43);
    send_frame(f8(8'h9A, 1'b1), 10);
    expect_rx("R12 accept", 8'hB5, 8'h9A);

    // R13: two-tick start glitch is abandoned, receiver still works
    wr(1'b0, 8'h90);
    @(negedge clk); rxd = 1'b0;
    wait_ticks(2);
    rxd = 1'b1;
    wait_ticks(40);
    expect_rx("R13 glitch", 8'h90, 8'h9A);
    send_frame(f8(8'h5C, 1'b1), 10);
    expect_rx("R13 after", 8'h95, 8'h5C);

    // R6: bit 6 reads zero, all other bits written
    wr(1'b0, 8'hFF);
    rd(1'b0, v); chk("R6 bit6", v, 8'hBF);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk + irq_chk, n_fail + irq_fail);
    $finish;
  end
endmodule